// File: doc/BRIEF.md
# USB Endpoint DMA Event Controller

This block holds the event flags, data-toggle tracking and stop control for an automatic DMA engine bound to a single USB endpoint. The packet engine reports every finished packet with one strobe and its status: direction, receive failure, handshake received, short length and the toggle bit the packet carried. The block keeps the toggle that the next packet should carry. It raises an error flag when a packet fails or carries the wrong toggle, and it can hold back repeated error flags behind a saturating error counter.

DMA starts when firmware writes the control register with both the enable and the automatic-mode bit set. There are two ways to stop. Clearing only the automatic-mode bit lets the packet in flight finish before the halt flag rises. Clearing the enable, or touching the endpoint's FIFO or its control/status registers while running, stops at once. A mask register chooses which flags drive the shared DMA interrupt bit.

Top module: `usb_dma_evctl`

## Requirements
- R1: After reset all four event flags, `next_tgl`, `dma_irq`, `dma_active` and `err_cnt` are 0, and the mask is 0.
- R2: A control write loads `next_tgl` from `ctl_tgl`. Each `pkt_done` while `dma_active` is 1 inverts it. A `pkt_done` while inactive changes neither `next_tgl` nor any flag.
- R3: When a control write and an accepted packet occur in the same cycle, `next_tgl` takes the written value.
- R4: An accepted packet sets `evt_err` when it is a receive (`pkt_tx`=0) with `pkt_rx_err`=1, or a transmit (`pkt_tx`=1) with `pkt_tx_ack`=0.
- R5: An accepted packet whose `pkt_tgl` differs from `next_tgl` as it stood before that packet sets `evt_err`.
- R6: With `err_cnt` gating enabled, an error sets `evt_err` only when `err_cnt` is 0. Every error adds 1 to `err_cnt`, which stops at 2^CNT_W-1. A write to the count register loads both the enable and the count, and that write wins over an increment. With gating off, every error sets `evt_err` and `err_cnt` is left unchanged.
- R7: `evt_cntz` sets in any cycle in which `cnt_zero` is 1, so it survives a read while `cnt_zero` stays 1.
- R8: `evt_short` sets only for an accepted receive packet with `pkt_short`=1. On transmit the short indication is ignored.
- R9: A control write with enable=1 and auto=0 while running leaves `dma_active` at 1 if `xfer_busy` is 1. The next accepted packet then clears `dma_active` and sets `evt_halt`. If `xfer_busy` is 0, the halt happens at once. FIFO and register accesses do not halt during this wait.
- R10: A control write with enable=0 while active clears `dma_active` and sets `evt_halt` on the next edge. While idle it sets nothing.
- R11: While running with both control bits set, `fw_fifo_acc` or `fw_ep_acc` clears `dma_active` and sets `evt_halt` on the next edge. While idle these inputs have no effect.
- R12: `dma_irq` is 1 exactly when some flag is set and its mask bit is 1. The mask bit order is 0 halt, 1 error, 2 count-zero, 3 short. `next_tgl` never drives `dma_irq`.
- R13: Flags are sticky until `evt_rd`. A read clears them, but a flag set in the same cycle as the read stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_dma_en | input | 1 | Written DMA enable |
| ctl_auto_en | input | 1 | Written automatic-mode bit |
| ctl_tgl | input | 1 | Written initial toggle |
| msk_wr | input | 1 | Mask register write strobe |
| msk_wdata | input | 4 | Mask value (0 halt, 1 error, 2 count-zero, 3 short) |
| errc_wr | input | 1 | Error-count register write strobe |
| errc_en | input | 1 | Written error-gating enable |
| errc_cnt | input | CNT_W | Written error count |
| evt_rd | input | 1 | Event register read strobe (clears flags) |
| cnt_zero | input | 1 | DMA transfer count equals zero |
| xfer_busy | input | 1 | A packet is in flight |
| pkt_done | input | 1 | Packet completion strobe |
| pkt_tx | input | 1 | 1 transmit, 0 receive |
| pkt_rx_err | input | 1 | Receive failed |
| pkt_tx_ack | input | 1 | Handshake received after transmit |
| pkt_short | input | 1 | Packet shorter than the FIFO |
| pkt_tgl | input | 1 | Toggle carried by the packet |
| fw_fifo_acc | input | 1 | Firmware FIFO access in the active direction |
| fw_ep_acc | input | 1 | Firmware access to endpoint control/status |
| evt_halt | output | 1 | Halt flag |
| evt_err | output | 1 | Error flag |
| evt_cntz | output | 1 | Count-zero flag |
| evt_short | output | 1 | Short-packet flag |
| next_tgl | output | 1 | Toggle expected or sent next |
| dma_irq | output | 1 | Masked DMA interrupt bit |
| dma_active | output | 1 | DMA running or draining |
| err_cnt | output | CNT_W | Error count register |

## Verification
The hardest state to reach is the graceful drain. The engine must be running, then a control write must clear only the automatic-mode bit while `xfer_busy` is held, and a FIFO access must arrive during the wait to show that it is ignored. The stimulus builds this in order and then completes the packet to release the halt. The same-cycle collisions are driven as joint strobes: a toggle write together with a packet, and an error together with a read. Error gating is driven by reloading the count to zero and to one below saturation between bursts of failing packets.

// File: rtl/ued_pkg.sv
package ued_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2
   } run_st_t;

   localparam int EV_HALT  = 0;
   localparam int EV_ERR   = 1;
   localparam int EV_CNTZ  = 2;
   localparam int EV_SHORT = 3;
   localparam int NUM_EV   = 4;
endpackage

// File: rtl/ued_toggle.sv
module ued_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic ld,
   input  logic ld_val,
   input  logic adv,
   output logic tgl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   tgl <= 1'b0;
      else if (ld)  tgl <= ld_val;
      else if (adv) tgl <= ~tgl;
   end

   p_tgl_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> tgl == $past(ld_val));
   p_tgl_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && adv) |=> tgl != $past(tgl));
   p_tgl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !adv) |=> tgl == $past(tgl));
endmodule

// File: rtl/ued_errgate.sv
module ued_errgate #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             err_raw,
   input  logic             cfg_wr,
   input  logic             cfg_en,
   input  logic [CNT_W-1:0] cfg_cnt,
   output logic             err_set,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic gate_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_en <= 1'b0;
         cnt     <= '0;
      end else if (cfg_wr) begin
         gate_en <= cfg_en;
         cnt     <= cfg_cnt;
      end else if (err_raw && gate_en && cnt != CNT_MAX) begin
         cnt <= cnt + 1'b1;
      end
   end

   always_comb err_set = err_raw && (!gate_en || cnt == '0);

   p_cnt_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_wr && cnt == CNT_MAX) |=> cnt == CNT_MAX);
   p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_wr && gate_en && err_raw && cnt != CNT_MAX)
      |=> cnt == CNT_W'($past(cnt) + 1'b1));
   p_cnt_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_wr && !err_raw) |=> $stable(cnt));
endmodule

// File: rtl/ued_halt.sv
module ued_halt
   import ued_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_wr,
   input  logic ctl_en,
   input  logic ctl_auto,
   input  logic xfer_busy,
   input  logic pkt_seen,
   input  logic fw_fifo_acc,
   input  logic fw_ep_acc,
   output logic active,
   output logic halt_set
);
   run_st_t st, st_nx;

   always_comb begin
      st_nx    = st;
      halt_set = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (ctl_wr && ctl_en && ctl_auto) st_nx = ST_RUN;
         end
         ST_RUN: begin
            if (ctl_wr) begin
               if (!ctl_en) begin
                  st_nx = ST_IDLE;  halt_set = 1'b1;
               end else if (!ctl_auto) begin
                  if (xfer_busy) st_nx = ST_DRAIN;
                  else begin
                     st_nx = ST_IDLE;  halt_set = 1'b1;
                  end
               end
            end else if (fw_fifo_acc || fw_ep_acc) begin
               st_nx = ST_IDLE;  halt_set = 1'b1;
            end
         end
         ST_DRAIN: begin
            if (ctl_wr) begin
               if (!ctl_en) begin
                  st_nx = ST_IDLE;  halt_set = 1'b1;
               end else if (ctl_auto) st_nx = ST_RUN;
            end else if (pkt_seen) begin
               st_nx = ST_IDLE;  halt_set = 1'b1;
            end
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nx;
   end

   always_comb active = (st != ST_IDLE);

   p_drain_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DRAIN && !ctl_wr && !pkt_seen) |=> active);
   p_halt_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
      halt_set |=> !active);
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !ctl_wr) |=> st == ST_IDLE);
endmodule

// File: rtl/ued_evreg.sv
module ued_evreg #(
   parameter int NUM_EV  = 4,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EV-1:0] set_vec,
   input  logic              rd,
   input  logic              msk_wr,
   input  logic [NUM_EV-1:0] msk_wdata,
   output logic [NUM_EV-1:0] ev,
   output logic              irq
);
   logic [NUM_EV-1:0] msk;
   logic              irq_c;

   for (genvar i = 0; i < NUM_EV; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          ev[i] <= 1'b0;
         else if (set_vec[i]) ev[i] <= 1'b1;
         else if (rd)         ev[i] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      msk <= '0;
      else if (msk_wr) msk <= msk_wdata;
   end

   always_comb irq_c = |(ev & msk);

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_c;
      end
   end else begin : g_irq_comb
      always_comb irq = irq_c;
   end

   p_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> ((ev & $past(ev)) == $past(ev)));
   p_rdclr_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && set_vec == '0) |=> ev == '0);
endmodule

// File: rtl/usb_dma_evctl.sv
module usb_dma_evctl
   import ued_pkg::*;
#(
   parameter int CNT_W   = 4,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic             ctl_dma_en,
   input  logic             ctl_auto_en,
   input  logic             ctl_tgl,
   input  logic             msk_wr,
   input  logic [3:0]       msk_wdata,
   input  logic             errc_wr,
   input  logic             errc_en,
   input  logic [CNT_W-1:0] errc_cnt,
   input  logic             evt_rd,
   input  logic             cnt_zero,
   input  logic             xfer_busy,
   input  logic             pkt_done,
   input  logic             pkt_tx,
   input  logic             pkt_rx_err,
   input  logic             pkt_tx_ack,
   input  logic             pkt_short,
   input  logic             pkt_tgl,
   input  logic             fw_fifo_acc,
   input  logic             fw_ep_acc,
   output logic             evt_halt,
   output logic             evt_err,
   output logic             evt_cntz,
   output logic             evt_short,
   output logic             next_tgl,
   output logic             dma_irq,
   output logic             dma_active,
   output logic [CNT_W-1:0] err_cnt
);
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
      $error("usb_dma_evctl: CNT_W must lie in 1..16");
   end
   if (NUM_EV != 4) begin : g_bad_ev
      $error("usb_dma_evctl: mask port assumes four flags");
   end

   logic              pkt_take, pkt_fail, err_raw, err_set, halt_set;
   logic [NUM_EV-1:0] set_vec, ev;

   ued_halt u_halt (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(ctl_wr), .ctl_en(ctl_dma_en), .ctl_auto(ctl_auto_en),
      .xfer_busy(xfer_busy), .pkt_seen(pkt_done),
      .fw_fifo_acc(fw_fifo_acc), .fw_ep_acc(fw_ep_acc),
      .active(dma_active), .halt_set(halt_set)
   );

   always_comb begin
      pkt_take = pkt_done && dma_active;
      pkt_fail = pkt_tx ? !pkt_tx_ack : pkt_rx_err;
      err_raw  = pkt_take && (pkt_fail || (pkt_tgl != next_tgl));
   end

   ued_toggle u_tgl (
      .clk(clk), .rst_n(rst_n),
      .ld(ctl_wr), .ld_val(ctl_tgl), .adv(pkt_take),
      .tgl(next_tgl)
   );

   ued_errgate #(.CNT_W(CNT_W)) u_err (
      .clk(clk), .rst_n(rst_n),
      .err_raw(err_raw),
      .cfg_wr(errc_wr), .cfg_en(errc_en), .cfg_cnt(errc_cnt),
      .err_set(err_set), .cnt(err_cnt)
   );

   always_comb begin
      set_vec           = '0;
      set_vec[EV_HALT]  = halt_set;
      set_vec[EV_ERR]   = err_set;
      set_vec[EV_CNTZ]  = cnt_zero;
      set_vec[EV_SHORT] = pkt_take && !pkt_tx && pkt_short;
   end

   ued_evreg #(.NUM_EV(NUM_EV), .IRQ_REG(IRQ_REG)) u_ev (
      .clk(clk), .rst_n(rst_n),
      .set_vec(set_vec), .rd(evt_rd),
      .msk_wr(msk_wr), .msk_wdata(msk_wdata),
      .ev(ev), .irq(dma_irq)
   );

   always_comb begin
      evt_halt  = ev[EV_HALT];
      evt_err   = ev[EV_ERR];
      evt_cntz  = ev[EV_CNTZ];
      evt_short = ev[EV_SHORT];
   end

   p_kill_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ctl_dma_en && dma_active) |=> (!dma_active && evt_halt));
   p_short_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_short && !(pkt_done && dma_active && !pkt_tx && pkt_short))
      |=> !evt_short);
   p_cntz_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_zero |=> evt_cntz);
   p_idle_pkt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!dma_active && !ctl_wr && pkt_done) |=> $stable(next_tgl));
endmodule

// File: tb/sim_usb_dma_evctl.sv
`timescale 1ns/1ps
module sim_usb_dma_evctl;
   localparam int CNT_W = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ctl_wr = 0, ctl_dma_en = 0, ctl_auto_en = 0, ctl_tgl = 0;
   logic msk_wr = 0;
   logic [3:0] msk_wdata = '0;
   logic errc_wr = 0, errc_en = 0;
   logic [CNT_W-1:0] errc_cnt = '0;
   logic evt_rd = 0, cnt_zero = 0, xfer_busy = 0;
   logic pkt_done = 0, pkt_tx = 0, pkt_rx_err = 0, pkt_tx_ack = 0;
   logic pkt_short = 0, pkt_tgl = 0, fw_fifo_acc = 0, fw_ep_acc = 0;
   logic evt_halt, evt_err, evt_cntz, evt_short, next_tgl, dma_irq, dma_active;
   logic [CNT_W-1:0] err_cnt;

   int checks = 0, failures = 0;
   bit exp_tgl = 1'b0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   usb_dma_evctl #(.CNT_W(CNT_W)) u0 (.*);

   // [7]tx [6]rx_err [5]ack [4]short [3]tgl | [2]err [1]short [0]next toggle
   localparam int NVEC = 10;
   localparam logic [7:0] VEC [NVEC] = '{
      8'b0000_0001, 8'b0000_1000, 8'b0100_0101, 8'b0000_0100, 8'b0001_0011,
      8'b1010_1000, 8'b1000_0101, 8'b1011_1000, 8'b1010_1101, 8'b0101_1110
   };

   task automatic chk(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic ctl(input bit en, input bit au, input bit tg);
      ctl_wr = 1; ctl_dma_en = en; ctl_auto_en = au; ctl_tgl = tg;
      @(negedge clk);
      ctl_wr = 0;
      exp_tgl = tg;
   endtask

   task automatic pkt(input bit tx, input bit re, input bit ack, input bit sh, input bit tg);
      pkt_done = 1; pkt_tx = tx; pkt_rx_err = re; pkt_tx_ack = ack;
      pkt_short = sh; pkt_tgl = tg;
      @(negedge clk);
      pkt_done = 0; pkt_rx_err = 0; pkt_tx_ack = 0; pkt_short = 0;
   endtask

   task automatic bad_rx();
      pkt(1'b0, 1'b1, 1'b0, 1'b0, exp_tgl);
      exp_tgl = ~exp_tgl;
   endtask

   task automatic rd();
      evt_rd = 1;
      @(negedge clk);
      evt_rd = 0;
   endtask

   task automatic errc(input bit en, input logic [CNT_W-1:0] c);
      errc_wr = 1; errc_en = en; errc_cnt = c;
      @(negedge clk);
      errc_wr = 0;
   endtask

   task automatic pulse_fw(input bit fifo, input bit ep);
      fw_fifo_acc = fifo; fw_ep_acc = ep;
      @(negedge clk);
      fw_fifo_acc = 0; fw_ep_acc = 0;
   endtask

   initial begin
      #(200000 * 8);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(evt_halt, 0, "R1 halt");   chk(evt_err, 0, "R1 err");
      chk(evt_cntz, 0, "R1 cntz");   chk(evt_short, 0, "R1 short");
      chk(next_tgl, 0, "R1 tgl");    chk(dma_irq, 0, "R1 irq");
      chk(dma_active, 0, "R1 active"); chk(err_cnt, 0, "R1 cnt");

      // R2 packet while idle is ignored
      pkt(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
      chk(evt_err, 0, "R2 idle err");
      chk(evt_short, 0, "R2 idle short");
      chk(next_tgl, 0, "R2 idle tgl");

      ctl(1'b1, 1'b1, 1'b0);
      chk(dma_active, 1, "R2 start");

      // R4 R5 R8 R2 vector table
      for (int i = 0; i < NVEC; i++) begin
         pkt(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
         chk(evt_err, VEC[i][2], $sformatf("R4/R5 vec%0d err", i));
         chk(evt_short, VEC[i][1], $sformatf("R8 vec%0d short", i));
         chk(next_tgl, VEC[i][0], $sformatf("R2 vec%0d tgl", i));
         rd();
      end
      exp_tgl = 1'b0;

      // R3 write wins over packet inversion
      ctl_wr = 1; ctl_dma_en = 1; ctl_auto_en = 1; ctl_tgl = 0;
      pkt(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      ctl_wr = 0;
      chk(next_tgl, 0, "R3 write wins");
      chk(evt_err, 0, "R3 no err");
      exp_tgl = 1'b0;

      // R13 set wins over read in same cycle
      evt_rd = 1;
      bad_rx();
      evt_rd = 0;
      chk(evt_err, 1, "R13 set beats read");
      rd();
      chk(evt_err, 0, "R13 read clears");

      // R12 masking
      msk_wr = 1; msk_wdata = 4'b0010;
      @(negedge clk);
      msk_wr = 0;
      pkt(1'b0, 1'b0, 1'b0, 1'b1, exp_tgl); exp_tgl = ~exp_tgl;
      chk(evt_short, 1, "R12 short set");
      chk(dma_irq, 0, "R12 short masked");
      bad_rx();
      chk(dma_irq, 1, "R12 err unmasked");
      rd();
      chk(dma_irq, 0, "R12 irq after read");
      msk_wr = 1; msk_wdata = 4'b1111;
      @(negedge clk);
      msk_wr = 0;
      pkt(1'b0, 1'b0, 1'b0, 1'b0, exp_tgl); exp_tgl = ~exp_tgl;
      chk(next_tgl, exp_tgl, "R12 tgl moved");
      chk(dma_irq, 0, "R12 toggle no irq");

      // R7 count-zero flag
      cnt_zero = 1;
      @(negedge clk);
      chk(evt_cntz, 1, "R7 set");
      chk(dma_irq, 1, "R12 cntz irq");
      rd();
      chk(evt_cntz, 1, "R7 resets while zero");
      cnt_zero = 0;
      rd();
      chk(evt_cntz, 0, "R7 clears");
      msk_wr = 1; msk_wdata = 4'b0000;
      @(negedge clk);
      msk_wr = 0;

      // R6 error gating
      errc(1'b1, 4'd0);
      bad_rx();
      chk(evt_err, 1, "R6 first err");
      chk(err_cnt, 1, "R6 cnt 1");
      rd();
      bad_rx();
      chk(evt_err, 0, "R6 gated");
      chk(err_cnt, 2, "R6 cnt 2");
      errc(1'b1, 4'd0);
      chk(err_cnt, 0, "R6 cleared");
      bad_rx();
      chk(evt_err, 1, "R6 after clear");
      rd();
      errc(1'b1, 4'd14);
      bad_rx();
      chk(err_cnt, 15, "R6 to max");
      chk(evt_err, 0, "R6 gated at 14");
      bad_rx();
      chk(err_cnt, 15, "R6 saturate");
      errc(1'b0, 4'd0);
      bad_rx();
      chk(evt_err, 1, "R6 gate off");
      chk(err_cnt, 0, "R6 no count when off");
      rd();

      // R11 firmware access halts
      pulse_fw(1'b0, 1'b1);
      chk(dma_active, 0, "R11 ep stop");
      chk(evt_halt, 1, "R11 ep halt");
      rd();
      ctl(1'b1, 1'b1, 1'b0);
      pulse_fw(1'b1, 1'b0);
      chk(dma_active, 0, "R11 fifo stop");
      chk(evt_halt, 1, "R11 fifo halt");
      rd();
      pulse_fw(1'b1, 1'b1);
      chk(evt_halt, 0, "R11 idle ignored");

      // R9 graceful stop
      ctl(1'b1, 1'b1, 1'b0);
      xfer_busy = 1;
      ctl(1'b1, 1'b0, 1'b0);
      chk(dma_active, 1, "R9 draining");
      chk(evt_halt, 0, "R9 no halt yet");
      pulse_fw(1'b1, 1'b0);
      chk(dma_active, 1, "R9 access ignored");
      chk(evt_halt, 0, "R9 access no halt");
      pkt(1'b0, 1'b0, 1'b0, 1'b0, exp_tgl);
      xfer_busy = 0;
      chk(dma_active, 0, "R9 done stop");
      chk(evt_halt, 1, "R9 halt after pkt");
      rd();
      ctl(1'b1, 1'b1, 1'b0);
      ctl(1'b1, 1'b0, 1'b0);
      chk(dma_active, 0, "R9 idle stop");
      chk(evt_halt, 1, "R9 idle halt");
      rd();

      // R10 immediate stop
      ctl(1'b1, 1'b1, 1'b0);
      ctl(1'b0, 1'b0, 1'b0);
      chk(dma_active, 0, "R10 stop");
      chk(evt_halt, 1, "R10 halt");
      rd();
      ctl(1'b0, 1'b0, 1'b0);
      chk(evt_halt, 0, "R10 idle no halt");

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule